// File: doc/BRIEF.md
# Three-Wire Mode Register Port

This block receives 16-bit control words over a three-line serial port (serial clock, serial data, load strobe) and holds the result in a mode register. It drives six output-enable bits and a 3-bit sampling-rate code to the clock generator around it. It runs entirely on the system clock. Each of the three serial lines passes through a two-flop synchroniser and then an edge detector. Data bits are taken on rising serial-clock edges while the load strobe is low.

When the load strobe rises, the received word is checked. The check covers the number of bits shifted in, the fixed header, the reserved bit and the rate code. A word that passes is copied into the register and a one-cycle commit pulse is raised. A word that fails leaves the register untouched and a one-cycle reject pulse is raised instead.

Top module: `serial_mode_port`

## Requirements
- R1: After reset `out_en_o` is 6'b111111, `rate_sel_o` is 3'b000 and both pulse outputs are low.
- R2: Bits are shifted MSB first, one per rising `ser_clk_i` edge while `ser_lat_i` is low. On a commit, `out_en_o[5:0]` takes word bits 9..4 (bit 5 = inverted 27 MHz output, 4 = 27 MHz output, 3 = 768fs, 2 = 384fs, 1 = 256fs, 0 = fixed 33.8688 MHz; 1 enables). `rate_sel_o` takes word bits 2..0.
- R3: A word whose bits 15..10 differ from 6'b011100 is rejected and the register keeps its value.
- R4: A word with reserved bit 3 set is rejected and the register keeps its value.
- R5: Rate codes 3'b011 and 3'b111 are rejected. Codes 000/001/010 (standard rate) and 100/101/110 (double rate) are accepted.
- R6: A word is rejected unless exactly 16 bits arrived since the previous strobe rise, even when the last 16 bits form a valid word.
- R7: Every strobe rise produces exactly one one-cycle pulse, either `commit_o` or `reject_o`, never both. The register changes only in a cycle where `commit_o` is high.
- R8: Serial-clock edges while the strobe is high shift no bits and are not counted.
- R9: The register and the commit pulse change on the third system-clock edge after the strobe rises at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_lat_i | input | 1 | Load strobe: low while shifting, rising edge loads |
| out_en_o | output | 6 | Output-enable bits |
| rate_sel_o | output | 3 | Sampling-rate code |
| commit_o | output | 1 | One-cycle pulse: word accepted |
| reject_o | output | 1 | One-cycle pulse: word discarded |

## Verification
The assertions assume the serial lines move slowly compared with the system clock. Each high or low phase of the serial clock must span several system clocks, so that every edge survives synchronisation. Data must change only while the serial clock is low, and the strobe must never change together with a serial-clock rise. The stimulus holds every serial-clock phase for four system clocks and changes data and strobe only in the low phase. Under those conditions the bench's delayed behavioural model sees the same edges as the design.

// File: rtl/smp_pkg.sv
package smp_pkg;
    // index of each serial line inside the synchronised bundle
    localparam int LINE_LAT = 0;
    localparam int LINE_DAT = 1;
    localparam int LINE_CLK = 2;
    localparam int LINE_N   = 3;
    // idle levels: strobe high, clock and data low
    localparam logic [LINE_N-1:0] LINE_IDLE = 3'b001;
endpackage

// File: rtl/smp_sync.sv
module smp_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/smp_edge.sv
module smp_edge #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/smp_shift.sv
module smp_shift #(
    parameter int WORD_W = 16,
    localparam int CNT_W = $clog2(WORD_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic              shift_i,
    input  logic              clear_i,
    input  logic              lat_i,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  count_o
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.cnt = '0;
        end else if (shift_i) begin
            s_d.word = {s_q.word[WORD_W-2:0], bit_i};
            if (s_q.cnt != SAT) s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_o  = s_q.word;
    assign count_o = s_q.cnt;

    // R6
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= SAT);

    // R8
    lat_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_i |=> (s_q.cnt == '0 || $stable(s_q.cnt)));
endmodule

// File: rtl/smp_word_check.sv
module smp_word_check #(
    parameter int              HDR_W   = 6,
    parameter logic [HDR_W-1:0] HDR_VAL = 6'b011100,
    parameter int              RATE_W  = 3,
    parameter int              WORD_W  = 16,
    localparam int             CNT_W   = $clog2(WORD_W + 2)
) (
    input  logic [HDR_W-1:0]  hdr_i,
    input  logic              rsv_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              ok_o
);
    logic len_ok, hdr_ok, rate_ok;

    always_comb begin
        len_ok  = (count_i == CNT_W'(WORD_W));
        hdr_ok  = (hdr_i == HDR_VAL);
        rate_ok = (rate_i[1:0] != 2'b11);
        ok_o    = len_ok && hdr_ok && !rsv_i && rate_ok;
    end
endmodule

// File: rtl/serial_mode_port.sv
module serial_mode_port
    import smp_pkg::*;
#(
    parameter int               WORD_W      = 16,
    parameter int               HDR_W       = 6,
    parameter logic [HDR_W-1:0] HDR_VAL     = 6'b011100,
    parameter int               EN_W        = 6,
    parameter int               RATE_W      = 3,
    parameter int               RSV_POS     = 3,
    parameter int               SYNC_STAGES = 2,
    parameter logic [EN_W-1:0]  EN_RST      = '1,
    parameter logic [RATE_W-1:0] RATE_RST   = '0,
    localparam int              CNT_W       = $clog2(WORD_W + 2),
    localparam int              EN_LSB      = RSV_POS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_lat_i,
    output logic [EN_W-1:0]   out_en_o,
    output logic [RATE_W-1:0] rate_sel_o,
    output logic              commit_o,
    output logic              reject_o
);
    logic [LINE_N-1:0] raw_lines, sync_lines, rise_lines;
    logic              shift_go, load_go, word_ok;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  count;

    assign raw_lines[LINE_LAT] = ser_lat_i;
    assign raw_lines[LINE_DAT] = ser_dat_i;
    assign raw_lines[LINE_CLK] = ser_clk_i;

    smp_sync #(.W(LINE_N), .STAGES(SYNC_STAGES), .RST_VAL(LINE_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_lines), .sync_o(sync_lines));

    smp_edge #(.W(LINE_N), .RST_VAL(LINE_IDLE)) u_edge (
        .clk(clk), .rst_n(rst_n), .level_i(sync_lines), .rise_o(rise_lines));

    assign shift_go = rise_lines[LINE_CLK] & ~sync_lines[LINE_LAT];
    assign load_go  = rise_lines[LINE_LAT];

    smp_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_i(sync_lines[LINE_DAT]),
        .shift_i(shift_go), .clear_i(load_go), .lat_i(sync_lines[LINE_LAT]),
        .word_o(word), .count_o(count));

    smp_word_check #(.HDR_W(HDR_W), .HDR_VAL(HDR_VAL), .RATE_W(RATE_W),
                     .WORD_W(WORD_W)) u_check (
        .hdr_i(word[WORD_W-1 -: HDR_W]), .rsv_i(word[RSV_POS]),
        .rate_i(word[RATE_W-1:0]), .count_i(count), .ok_o(word_ok));

    typedef struct packed {
        logic [EN_W-1:0]   en;
        logic [RATE_W-1:0] rate;
        logic              commit;
        logic              reject;
    } mode_t;

    mode_t m_d, m_q;

    always_comb begin
        m_d        = m_q;
        m_d.commit = 1'b0;
        m_d.reject = 1'b0;
        if (load_go) begin
            if (word_ok) begin
                m_d.en     = word[EN_LSB +: EN_W];
                m_d.rate   = word[RATE_W-1:0];
                m_d.commit = 1'b1;
            end else begin
                m_d.reject = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '{en: EN_RST, rate: RATE_RST, commit: 1'b0, reject: 1'b0};
        else        m_q <= m_d;
    end

    assign out_en_o   = m_q.en;
    assign rate_sel_o = m_q.rate;
    assign commit_o   = m_q.commit;
    assign reject_o   = m_q.reject;

    // R7
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && reject_o));

    // R7
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    // R7
    en_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en_o != $past(out_en_o) || rate_sel_o != $past(rate_sel_o)) |-> commit_o);

    // R5
    rate_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (rate_sel_o[1:0] != 2'b11));
endmodule

// File: tb/serial_mode_port_test.sv
module serial_mode_port_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, slat = 1'b1;
    logic [5:0] en;
    logic [2:0] rate;
    logic commit, reject;

    serial_mode_port uut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
        .ser_lat_i(slat), .out_en_o(en), .rate_sel_o(rate),
        .commit_o(commit), .reject_o(reject));

    int n_cmp = 0, n_bad = 0;
    int commits = 0, rejects = 0;
    bit done = 1'b0;

    // behavioural model: raw samples delayed through a queue
    logic [2:0]  hist[$];
    logic [15:0] m_word;
    int          m_cnt;
    logic [5:0]  m_en;
    logic [2:0]  m_rate;
    logic        m_commit, m_reject;

    always @(posedge clk) begin
        logic [2:0] raw, cur, old;
        raw = {sclk, sdat, slat};
        if (!rst_n) begin
            hist.delete();
            repeat (3) hist.push_back(3'b001);
            m_word = '0; m_cnt = 0; m_en = 6'h3F; m_rate = 3'd0;
            m_commit = 1'b0; m_reject = 1'b0;
        end else begin
            old = hist[0];
            cur = hist[1];
            m_commit = 1'b0;
            m_reject = 1'b0;
            if (cur[0] && !old[0]) begin
                if (m_cnt == 16 && m_word[15:10] == 6'b011100 && !m_word[3]
                    && m_word[1:0] != 2'b11) begin
                    m_en = m_word[9:4]; m_rate = m_word[2:0]; m_commit = 1'b1;
                end else begin
                    m_reject = 1'b1;
                end
                m_cnt = 0;
            end else if (cur[2] && !old[2] && !cur[0]) begin
                m_word = {m_word[14:0], cur[1]};
                if (m_cnt < 17) m_cnt++;
            end
            void'(hist.pop_front());
            hist.push_back(raw);
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R2 enables vs model", en, m_en);
            cmp("R5 rate vs model", rate, m_rate);
            cmp("R7 commit vs model", commit, m_commit);
            cmp("R7 reject vs model", reject, m_reject);
            if (commit) commits++;
            if (reject) rejects++;
        end
    end

    task automatic bits_out(input logic [31:0] w, input int n);
        @(negedge clk); slat = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = w[i];
            repeat (4) @(negedge clk); sclk = 1'b1;
            repeat (4) @(negedge clk); sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] w, input int n);
        bits_out(w, n);
        slat = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic expect_word(input logic [31:0] w, input int n, input bit ok,
                               input logic [5:0] xen, input logic [2:0] xrate,
                               input string tag);
        int c0, r0;
        c0 = commits; r0 = rejects;
        send(w, n);
        cmp({tag, " commit count"}, commits - c0, ok ? 1 : 0);
        cmp({tag, " reject count"}, rejects - r0, ok ? 0 : 1);
        cmp({tag, " enables"}, en, xen);
        cmp({tag, " rate"}, rate, xrate);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp("R1 enables at reset", en, 6'h3F);
        cmp("R1 rate at reset", rate, 3'd0);
        cmp("R1 pulses at reset", {commit, reject}, 2'b00);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 accepted words
        expect_word(32'h72A5, 16, 1'b1, 6'b101010, 3'b101, "R2 word 72A5");
        expect_word(32'h7004, 16, 1'b1, 6'b000000, 3'b100, "R2 all disabled");
        expect_word(32'h72A5, 16, 1'b1, 6'b101010, 3'b101, "R2 reload");
        // R3 header
        expect_word(32'h6156, 16, 1'b0, 6'b101010, 3'b101, "R3 bad header");
        expect_word(32'hF156, 16, 1'b0, 6'b101010, 3'b101, "R3 bad top bit");
        // R4 reserved
        expect_word(32'h715E, 16, 1'b0, 6'b101010, 3'b101, "R4 reserved set");
        // R5 prohibited rates
        expect_word(32'h7153, 16, 1'b0, 6'b101010, 3'b101, "R5 code 011");
        expect_word(32'h7157, 16, 1'b0, 6'b101010, 3'b101, "R5 code 111");
        expect_word(32'h7152, 16, 1'b1, 6'b010101, 3'b010, "R5 code 010");
        // R6 length
        expect_word(32'h72A5, 15, 1'b0, 6'b010101, 3'b010, "R6 fifteen bits");
        expect_word(32'h072A5, 17, 1'b0, 6'b010101, 3'b010, "R6 seventeen bits");
        // R8 serial clocks with strobe high
        sdat = 1'b1;
        for (int k = 0; k < 5; k++) begin
            repeat (4) @(negedge clk); sclk = 1'b1;
            repeat (4) @(negedge clk); sclk = 1'b0;
        end
        sdat = 1'b0;
        expect_word(32'h7156, 16, 1'b1, 6'b010101, 3'b110, "R8 clocks ignored");

        // R9 latency from strobe pin to register
        bits_out(32'h73F0, 16);
        slat = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cmp("R9 unchanged after two edges", en, 6'b010101);
        cmp("R9 no pulse after two edges", commit, 1'b0);
        @(negedge clk);
        cmp("R9 enables on third edge", en, 6'h3F);
        cmp("R9 rate on third edge", rate, 3'd0);
        cmp("R9 commit on third edge", commit, 1'b1);
        @(negedge clk);
        cmp("R7 commit lasts one cycle", commit, 1'b0);
        repeat (6) @(negedge clk);

        expect_word(32'h72A5, 16, 1'b1, 6'b101010, 3'b101, "R2 before reset");
        // R1 reset returns defaults
        rst_n = 1'b0;
        @(negedge clk);
        cmp("R1 enables after reset", en, 6'h3F);
        cmp("R1 rate after reset", rate, 3'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule